// File: doc/BRIEF.md
# Controlled-Swap Tree Binary Decoder

This block is an N-to-2^N binary decoder built only from three-line controlled-swap cells. Each cell passes its control line through and exchanges its other two lines when the control is 1. The block is a fixed bundle of N + 2^N lines. N of them carry the select bits. The other 2^N start as constants: one line holds 1 and the rest hold 0. A tree of swap stages then steers the single 1 onto the decode line whose index equals the select value. The select bits leave the block unchanged as garbage lines, so the number of lines going in equals the number coming out.

Every cell undoes itself, and the cells within a stage touch disjoint lines. The whole map is therefore a permutation of the line vector. An instance built with the stage order mirrored undoes it exactly. A raw mode lets the full input line vector be driven directly, so the network can be exercised with any constant pattern. The main use of this mode is to pair a forward instance with a mirrored one.

Top module: `rev_fredkin_decoder`

## Requirements
- R1: Each cell with control A and data lines B, C gives P = A, Q = B when A is 0 and C when A is 1, and R = C when A is 0 and B when A is 1. For N = 1 in raw mode, line 2 is A, line 0 is B and line 1 is C on input. On output, line 2 is P, line 0 is Q and line 1 is R.
- R2: In standard mode (raw_en = 0), exactly one of the decode lines lines_out[2^N-1:0] is 1, and its index equals sel. sel[N-1] is the most significant bit.
- R3: In standard mode, the garbage lines lines_out[N+2^N-1:2^N] equal sel. The internal constant pattern puts 1 on line 0, 0 on lines 1 to 2^N-1, and sel on the top N lines.
- R4: The number of 1s on lines_out always equals the number of 1s on the line vector fed into the network.
- R5: In raw mode (raw_en = 1), raw_lines is the network input and sel has no effect. The forward map is a bijection over all 2^(N+2^N) line vectors. A vector whose data lines are all 0 gives all-0 decode lines.
- R6: An instance with REVERSE = 1, in raw mode and fed with a forward instance's lines_out, reproduces the forward instance's network input exactly.
- R7: For N = 1, standard mode gives lines_out = {sel, sel, ~sel}.
- R8: In standard mode, raw_lines has no effect on lines_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | N | Select value; sel[N-1] controls the first stage |
| raw_en | input | 1 | 1: drive the network from raw_lines; 0: use sel and fixed constants |
| raw_lines | input | N+2^N | Full line vector used in raw mode |
| lines_out | output | N+2^N | Decode lines in the low 2^N bits, garbage lines above |

## Verification
The hardest case to reach from the ports is the claim that the network is a true permutation under arbitrary constants, because standard mode only ever applies 2^N of the possible line vectors. Raw mode is the way in. The bench drives every one of the 2048 eleven-line vectors into the default instance and marks each output in a bitmap to catch any collision. The same outputs go through a mirrored instance, which must return the original vector. This also checks that the ones count on the lines is conserved for every vector.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    typedef enum logic {
        SRC_STD = 1'b0,
        SRC_RAW = 1'b1
    } line_src_e;

    function automatic int unsigned data_lines(int unsigned n);
        return 32'd1 << n;
    endfunction

    function automatic int unsigned line_total(int unsigned n);
        return n + data_lines(n);
    endfunction

    // stage k (1-based) has 2^(k-1) cells
    function automatic int unsigned stage_cells(int unsigned k);
        return 32'd1 << (k - 1);
    endfunction

    // B line of cell g in stage k: prefix g spaced by 2^(n-k+1)
    function automatic int unsigned cell_lo(int unsigned n, int unsigned k, int unsigned g);
        return g * (32'd1 << (n - k + 1));
    endfunction

    // C line: halfway to the next prefix, never touched by earlier stages
    function automatic int unsigned cell_hi(int unsigned n, int unsigned k, int unsigned g);
        return cell_lo(n, k, g) + (32'd1 << (n - k));
    endfunction

    // line carrying select bit n-k
    function automatic int unsigned ctl_line(int unsigned n, int unsigned k);
        return data_lines(n) + (n - k);
    endfunction

endpackage

// File: rtl/fredkin_cell.sv
module fredkin_cell (
    input  logic a_in,
    input  logic b_in,
    input  logic c_in,
    output logic p_out,
    output logic q_out,
    output logic r_out
);
    always_comb begin
        p_out = a_in;
        q_out = a_in ? c_in : b_in;
        r_out = a_in ? b_in : c_in;
    end

    always_comb begin
        if (!$isunknown({a_in, b_in, c_in})) begin
            p_keep_ones_r4: assert ($countones({p_out, q_out, r_out}) == $countones({a_in, b_in, c_in}))
                else $error("cell changed ones count");
            p_data_set_r1: assert ({q_out, r_out} == {b_in, c_in} || {q_out, r_out} == {c_in, b_in})
                else $error("cell output not a swap of inputs");
        end
    end
endmodule

// File: rtl/rdec_line_src.sv
module rdec_line_src
    import rdec_pkg::*;
#(
    parameter int unsigned N = 3,
    localparam int unsigned L = line_total(N),
    localparam int unsigned D = data_lines(N)
) (
    input  logic [N-1:0] sel,
    input  logic         raw_en,
    input  logic [L-1:0] raw_lines,
    output logic [L-1:0] net_in
);
    line_src_e src;

    always_comb begin
        src = line_src_e'(raw_en);
        case (src)
            SRC_RAW: net_in = raw_lines;
            default: begin
                net_in          = '0;
                net_in[0]       = 1'b1;
                net_in[L-1:D]   = sel;
            end
        endcase
    end
endmodule

// File: rtl/rdec_stage.sv
module rdec_stage
    import rdec_pkg::*;
#(
    parameter int unsigned N = 3,
    parameter int unsigned K = 1,
    localparam int unsigned L = line_total(N),
    localparam int unsigned G = stage_cells(K),
    localparam int unsigned CTL = ctl_line(N, K)
) (
    input  logic [L-1:0] lines_in,
    output logic [L-1:0] lines_out
);
    logic ctl_chain [G+1];
    logic q_w [G];
    logic r_w [G];

    assign ctl_chain[0] = lines_in[CTL];

    // the control line threads through every cell of the stage
    for (genvar g = 0; g < G; g++) begin : g_cell
        fredkin_cell u_cell (
            .a_in  (ctl_chain[g]),
            .b_in  (lines_in[cell_lo(N, K, g)]),
            .c_in  (lines_in[cell_hi(N, K, g)]),
            .p_out (ctl_chain[g+1]),
            .q_out (q_w[g]),
            .r_out (r_w[g])
        );
    end

    always_comb begin
        lines_out = lines_in;
        for (int g = 0; g < G; g++) begin
            lines_out[cell_lo(N, K, g)] = q_w[g];
            lines_out[cell_hi(N, K, g)] = r_w[g];
        end
        lines_out[CTL] = ctl_chain[G];
    end

    always_comb begin
        if (!$isunknown(lines_in)) begin
            p_ctl_through_r3: assert (lines_out[L-1:data_lines(N)] == lines_in[L-1:data_lines(N)])
                else $error("stage altered a select line");
        end
    end
endmodule

// File: rtl/rev_fredkin_decoder.sv
module rev_fredkin_decoder
    import rdec_pkg::*;
#(
    parameter int unsigned N = 3,
    parameter bit REVERSE = 1'b0,
    localparam int unsigned L = line_total(N),
    localparam int unsigned D = data_lines(N)
) (
    input  logic [N-1:0] sel,
    input  logic         raw_en,
    input  logic [L-1:0] raw_lines,
    output logic [L-1:0] lines_out
);
    logic [L-1:0] tap [N+1];

    rdec_line_src #(.N(N)) u_src (
        .sel       (sel),
        .raw_en    (raw_en),
        .raw_lines (raw_lines),
        .net_in    (tap[0])
    );

    for (genvar s = 0; s < N; s++) begin : g_stage
        localparam int unsigned K = REVERSE ? (N - s) : (s + 1);
        rdec_stage #(.N(N), .K(K)) u_stage (
            .lines_in  (tap[s]),
            .lines_out (tap[s+1])
        );
    end

    assign lines_out = tap[N];

    always_comb begin
        if (!$isunknown({sel, raw_en, raw_lines})) begin
            p_ones_kept_r4: assert ($countones(lines_out) == $countones(tap[0]))
                else $error("network changed ones count");
            if (!REVERSE && !raw_en) begin
                p_onehot_r2: assert ($onehot(lines_out[D-1:0]))
                    else $error("decode lines not one-hot");
                p_index_r2: assert (lines_out[sel] == 1'b1)
                    else $error("wrong decode line asserted");
                p_garbage_r3: assert (lines_out[L-1:D] == sel)
                    else $error("garbage lines differ from select");
            end
        end
    end
endmodule

// File: tb/sim_rev_fredkin_decoder.sv
module sim_rev_fredkin_decoder;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] DEC_TAB [8] = '{8'h01, 8'h02, 8'h04, 8'h08,
                                           8'h10, 8'h20, 8'h40, 8'h80};

    logic [2:0]  sel3 = '0;
    logic        raw3 = 1'b0;
    logic [10:0] rl3 = '0;
    logic [10:0] out3, inv3;
    logic [0:0]  sel1 = '0;
    logic        raw1 = 1'b0;
    logic [2:0]  rl1 = '0;
    logic [2:0]  out1;
    logic [3:0]  sel4 = '0;
    logic [19:0] out4;
    logic [2:0]  zsel = '0;

    rev_fredkin_decoder #(.N(3), .REVERSE(1'b0)) u0 (
        .sel(sel3), .raw_en(raw3), .raw_lines(rl3), .lines_out(out3));
    rev_fredkin_decoder #(.N(3), .REVERSE(1'b1)) u_inv (
        .sel(zsel), .raw_en(1'b1), .raw_lines(out3), .lines_out(inv3));
    rev_fredkin_decoder #(.N(1), .REVERSE(1'b0)) u_one (
        .sel(sel1), .raw_en(raw1), .raw_lines(rl1), .lines_out(out1));
    rev_fredkin_decoder #(.N(4), .REVERSE(1'b0)) u_four (
        .sel(sel4), .raw_en(1'b0), .raw_lines(20'h0), .lines_out(out4));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    bit seen [2048];

    initial begin
        logic [10:0] ref_out;
        int hits;
        @(posedge clk);

        // table walk: R2, R3, R6
        for (int i = 0; i < 8; i++) begin
            sel3 = i[2:0]; raw3 = 1'b0;
            @(negedge clk);
            chk(out3[7:0] == DEC_TAB[i], "R2", 32'(out3[7:0]), 32'(DEC_TAB[i]));
            chk(out3[10:8] == i[2:0], "R3", 32'(out3[10:8]), 32'(i));
            chk(inv3 == {i[2:0], 8'h01}, "R6", 32'(inv3), 32'({i[2:0], 8'h01}));
            @(posedge clk);
        end

        // R8: raw_lines ignored in standard mode
        sel3 = 3'd5; raw3 = 1'b0; rl3 = '0;
        @(negedge clk);
        ref_out = out3;
        for (int v = 0; v < 4; v++) begin
            @(posedge clk);
            rl3 = 11'h5A3 ^ (11'h0F1 << v);
            @(negedge clk);
            chk(out3 == ref_out, "R8", 32'(out3), 32'(ref_out));
        end

        // R7: N = 1 standard mode
        for (int s = 0; s < 2; s++) begin
            @(posedge clk);
            sel1 = s[0:0]; raw1 = 1'b0;
            @(negedge clk);
            chk(out1 == {s[0], s[0], ~s[0]}, "R7", 32'(out1), 32'({s[0], s[0], ~s[0]}));
        end

        // R1: single cell truth table via N = 1 raw mode
        for (int v = 0; v < 8; v++) begin
            logic a, b, c;
            logic [2:0] e;
            a = v[2]; b = v[0]; c = v[1];
            e = {a, (a ? b : c), (a ? c : b)};
            @(posedge clk);
            raw1 = 1'b1; rl1 = v[2:0];
            @(negedge clk);
            chk(out1 == e, "R1", 32'(out1), 32'(e));
        end

        // R2 at N = 4
        for (int s = 0; s < 16; s++) begin
            @(posedge clk);
            sel4 = s[3:0];
            @(negedge clk);
            chk(out4[15:0] == (16'h1 << s), "R2", 32'(out4[15:0]), 32'(16'h1 << s));
            chk(out4[19:16] == s[3:0], "R3", 32'(out4[19:16]), 32'(s));
        end

        // R5, R4, R6: exhaustive raw mode for N = 3
        for (int v = 0; v < 2048; v++) seen[v] = 1'b0;
        hits = 0;
        for (int v = 0; v < 2048; v++) begin
            @(posedge clk);
            raw3 = 1'b1; rl3 = v[10:0]; sel3 = v[2:0];
            @(negedge clk);
            chk(!seen[out3], "R5", 32'(out3), 32'(v));
            if (!seen[out3]) hits++;
            seen[out3] = 1'b1;
            chk($countones(out3) == $countones(v[10:0]), "R4",
                32'($countones(out3)), 32'($countones(v[10:0])));
            chk(inv3 == v[10:0], "R6", 32'(inv3), 32'(v));
        end
        chk(hits == 2048, "R5", 32'(hits), 32'd2048);

        // R5: all-zero data lines, sel has no effect in raw mode
        for (int s = 0; s < 8; s++) begin
            @(posedge clk);
            raw3 = 1'b1; rl3 = 11'b110_00000000; sel3 = s[2:0];
            @(negedge clk);
            chk(out3 == 11'b110_00000000, "R5", 32'(out3), 32'h600);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule